// File: doc/BRIEF.md
# Capture-Delay Calibration Sweep

This controller picks a delay setting for a secondary capture channel so that its samples land midway between the samples of a reference channel. Both channels capture the same rising ramp, and the secondary samples interleave with the reference samples. After a start command the controller steps its delay-select output through every setting, from the lowest to the highest. At each setting it first waits a programmable number of settle cycles. It then collects a window of sample pairs and judges whether every secondary sample falls strictly between the reference sample before it and the reference sample after it.

A setting passes only when every pair in its window is in order. When the sweep ends, the controller takes the first unbroken run of passing settings and chooses its centre. The centre sits furthest from the capture edges on either side. The controller drives the chosen setting onto the delay select and raises a done flag. If no setting passed, it raises an error flag instead and puts back the delay select it had before the sweep.

Top module: `dly_cal_sweep`

## Requirements
- R1: After reset, the delay select is 0, the chosen value is 0, and the done and error flags are 0.
- R2: A start pulse accepted while idle clears done and error. The controller then visits settings 0, 1, …, 2^TAP_W−1 on the delay select, each exactly once and in ascending order. A start pulse that arrives while a sweep is running has no effect.
- R3: The settle count is taken at start. After each change of the delay select, sample pairs presented in the next settle-count cycles are discarded.
- R4: A sample pair is taken only in a cycle where both valid strobes are high together. A cycle with only one strobe high is ignored.
- R5: Pairs are compared as unsigned numbers. A secondary sample is in order when it is strictly greater than the reference sample of its own pair and strictly less than the reference sample of the next pair. Equality in either direction counts as out of order. The first pair collected at a setting only sets the starting point and is not judged.
- R6: A setting passes only if all WIN consecutive judgements at that setting are in order. A single out-of-order pair fails the setting.
- R7: The valid range is the first unbroken run of passing settings. Passing settings after that run has ended are ignored.
- R8: When a range exists, the chosen value is floor((first+last)/2). It appears on both the chosen output and the delay select, with error at 0 and done at 1.
- R9: When no setting passes, error and done go to 1. The delay select returns to its value before the start, and the chosen output keeps its previous value.
- R10: Done, error, chosen value and delay select hold steady until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start-sweep pulse |
| settle_cycles_i | input | SET_W | Cycles to wait after each delay change, taken at start |
| ref_valid_i | input | 1 | Reference sample strobe |
| ref_sample_i | input | SMP_W | Reference channel sample |
| sec_valid_i | input | 1 | Secondary sample strobe |
| sec_sample_i | input | SMP_W | Secondary channel sample |
| dly_sel_o | output | TAP_W | Delay select for the secondary channel |
| cal_done_o | output | 1 | Sweep finished (held) |
| chosen_o | output | TAP_W | Centre of the valid range |
| cal_err_o | output | 1 | No setting passed (held) |

## Verification
The bench uses the defaults: 16 settings, 8-bit samples and a window of 8 pairs. It sweeps every single passing range (first ≤ last) over all 16 settings, which covers single-setting ranges, ranges at either end and the rounding of even-length ranges. The same runs vary the settle count from 0 to 9, feed out-of-order data during the settle cycles, alternate between strict and equal-value failing samples, and insert single-strobe junk cycles. Separate runs cover two disjoint ranges, a single bad pair inside an otherwise passing setting, a sweep where nothing passes, and a start pulse issued in the middle of a sweep.

// File: rtl/dly_cal_pkg.sv
package dly_cal_pkg;

  localparam int SMP_MAX = 16;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_COLLECT,
    ST_FINISH
  } cal_state_e;

  // Secondary sample must sit strictly between its neighbouring reference samples.
  function automatic logic pair_in_order(input logic [SMP_MAX-1:0] prev_ref,
                                         input logic [SMP_MAX-1:0] sec,
                                         input logic [SMP_MAX-1:0] next_ref);
    return (prev_ref < sec) && (sec < next_ref);
  endfunction

  // Centre of an inclusive tap range, rounded down.
  function automatic logic [7:0] mid_tap(input logic [7:0] first, input logic [7:0] last);
    logic [8:0] s;
    s = {1'b0, first} + {1'b0, last};
    return s[8:1];
  endfunction

endpackage

// File: rtl/dly_cal_tap_judge.sv
module dly_cal_tap_judge
  import dly_cal_pkg::*;
#(
  parameter int SMP_W = 8,
  parameter int WIN   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             pair_i,
  input  logic [SMP_W-1:0] ref_i,
  input  logic [SMP_W-1:0] sec_i,
  output logic             tap_done_o,
  output logic             tap_ok_o
);

  localparam int CNT_W = $clog2(WIN + 1);

  logic             have_prev_q;
  logic [SMP_W-1:0] prev_ref_q;
  logic [SMP_W-1:0] prev_sec_q;
  logic [CNT_W-1:0] cnt_q;
  logic             all_ok_q;

  logic accept_w;
  logic judge_w;
  logic pair_ok_w;

  assign accept_w  = en_i && pair_i;
  assign judge_w   = accept_w && have_prev_q;
  assign pair_ok_w = pair_in_order(SMP_MAX'(prev_ref_q), SMP_MAX'(prev_sec_q), SMP_MAX'(ref_i));

  assign tap_done_o = judge_w && (cnt_q == CNT_W'(WIN - 1));
  assign tap_ok_o   = all_ok_q && pair_ok_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev_q <= 1'b0;
      prev_ref_q  <= '0;
      prev_sec_q  <= '0;
      cnt_q       <= '0;
      all_ok_q    <= 1'b1;
    end else if (!en_i) begin
      have_prev_q <= 1'b0;
      cnt_q       <= '0;
      all_ok_q    <= 1'b1;
    end else if (accept_w) begin
      prev_ref_q  <= ref_i;
      prev_sec_q  <= sec_i;
      have_prev_q <= 1'b1;
      if (have_prev_q) begin
        cnt_q    <= cnt_q + CNT_W'(1);
        all_ok_q <= all_ok_q && pair_ok_w;
      end
    end
  end

  AST_WIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(WIN)); // R6
  AST_FIRST_PAIR_PRIMES: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w && !have_prev_q |=> have_prev_q && (cnt_q == $past(cnt_q))); // R5
  AST_SINGLE_STROBE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && !pair_i |=> (!en_i) || ($stable(cnt_q) && $stable(prev_ref_q))); // R4

endmodule

// File: rtl/dly_cal_range.sv
module dly_cal_range #(
  parameter int TAP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             tap_valid_i,
  input  logic [TAP_W-1:0] tap_idx_i,
  input  logic             tap_ok_i,
  output logic             found_o,
  output logic [TAP_W-1:0] first_o,
  output logic [TAP_W-1:0] last_o
);

  logic             found_q;
  logic             closed_q;
  logic [TAP_W-1:0] first_q;
  logic [TAP_W-1:0] last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      found_q  <= 1'b0;
      closed_q <= 1'b0;
      first_q  <= '0;
      last_q   <= '0;
    end else if (clear_i) begin
      found_q  <= 1'b0;
      closed_q <= 1'b0;
    end else if (tap_valid_i) begin
      if (tap_ok_i && !closed_q) begin
        if (!found_q) begin
          found_q <= 1'b1;
          first_q <= tap_idx_i;
        end
        last_q <= tap_idx_i;
      end else if (!tap_ok_i && found_q) begin
        closed_q <= 1'b1;
      end
    end
  end

  assign found_o = found_q;
  assign first_o = first_q;
  assign last_o  = last_q;

  AST_RANGE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    found_q |-> (first_q <= last_q)); // R7
  AST_CLOSED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    closed_q && !clear_i |=> $stable(first_q) && $stable(last_q)); // R7

endmodule

// File: rtl/dly_cal_sweep.sv
module dly_cal_sweep
  import dly_cal_pkg::*;
#(
  parameter int TAP_W = 4,
  parameter int SMP_W = 8,
  parameter int WIN   = 8,
  parameter int SET_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [SET_W-1:0] settle_cycles_i,
  input  logic             ref_valid_i,
  input  logic [SMP_W-1:0] ref_sample_i,
  input  logic             sec_valid_i,
  input  logic [SMP_W-1:0] sec_sample_i,
  output logic [TAP_W-1:0] dly_sel_o,
  output logic             cal_done_o,
  output logic [TAP_W-1:0] chosen_o,
  output logic             cal_err_o
);

  localparam logic [TAP_W-1:0] TAP_LAST = '1;

  cal_state_e       state_q;
  logic [TAP_W-1:0] dly_q;
  logic [TAP_W-1:0] saved_q;
  logic [TAP_W-1:0] chosen_q;
  logic [SET_W-1:0] settle_n_q;
  logic [SET_W-1:0] settle_cnt_q;
  logic             done_q;
  logic             err_q;

  logic             collect_en_w;
  logic             pair_w;
  logic             start_acc_w;
  logic             tap_done_w;
  logic             tap_ok_w;
  logic             found_w;
  logic [TAP_W-1:0] first_w;
  logic [TAP_W-1:0] last_w;
  logic [TAP_W-1:0] mid_w;

  assign collect_en_w = (state_q == ST_COLLECT);
  assign pair_w       = ref_valid_i && sec_valid_i;
  assign start_acc_w  = start_i && (state_q == ST_IDLE);
  assign mid_w        = TAP_W'(mid_tap(8'(first_w), 8'(last_w)));

  dly_cal_tap_judge #(
    .SMP_W (SMP_W),
    .WIN   (WIN)
  ) u_judge (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (collect_en_w),
    .pair_i     (pair_w),
    .ref_i      (ref_sample_i),
    .sec_i      (sec_sample_i),
    .tap_done_o (tap_done_w),
    .tap_ok_o   (tap_ok_w)
  );

  dly_cal_range #(
    .TAP_W (TAP_W)
  ) u_range (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (start_acc_w),
    .tap_valid_i (collect_en_w && tap_done_w),
    .tap_idx_i   (dly_q),
    .tap_ok_i    (tap_ok_w),
    .found_o     (found_w),
    .first_o     (first_w),
    .last_o      (last_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      dly_q        <= '0;
      saved_q      <= '0;
      chosen_q     <= '0;
      settle_n_q   <= '0;
      settle_cnt_q <= '0;
      done_q       <= 1'b0;
      err_q        <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_acc_w) begin
            saved_q      <= dly_q;
            dly_q        <= '0;
            settle_n_q   <= settle_cycles_i;
            settle_cnt_q <= settle_cycles_i;
            done_q       <= 1'b0;
            err_q        <= 1'b0;
            state_q      <= ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          if (settle_cnt_q == '0) state_q <= ST_COLLECT;
          else settle_cnt_q <= settle_cnt_q - SET_W'(1);
        end
        ST_COLLECT: begin
          if (tap_done_w) begin
            if (dly_q == TAP_LAST) begin
              state_q <= ST_FINISH;
            end else begin
              dly_q        <= dly_q + TAP_W'(1);
              settle_cnt_q <= settle_n_q;
              state_q      <= ST_SETTLE;
            end
          end
        end
        ST_FINISH: begin
          if (found_w) begin
            dly_q    <= mid_w;
            chosen_q <= mid_w;
          end else begin
            dly_q <= saved_q;
            err_q <= 1'b1;
          end
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign dly_sel_o  = dly_q;
  assign chosen_o   = chosen_q;
  assign cal_done_o = done_q;
  assign cal_err_o  = err_q;

  AST_SEL_HELD_COLLECT: assert property (@(posedge clk) disable iff (!rst_n)
    collect_en_w && !tap_done_w |=> $stable(dly_q)); // R3
  AST_SWEEP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    collect_en_w && tap_done_w && (dly_q != TAP_LAST) |=> dly_q == TAP_W'($past(dly_q) + TAP_W'(1))); // R2
  AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && collect_en_w && !tap_done_w |=> state_q == ST_COLLECT); // R2
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && !start_i |=> done_q && $stable(dly_q) && $stable(chosen_q)); // R10
  AST_ERR_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> dly_q == saved_q); // R9
  AST_PICK_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) && !err_q |-> chosen_q == dly_q); // R8
  AST_PICK_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) && !err_q |-> (chosen_q >= first_w) && (chosen_q <= last_w)); // R8

endmodule

// File: tb/dly_cal_sweep_tb.sv
module dly_cal_sweep_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TAP_W = 4;
  localparam int SMP_W = 8;
  localparam int SET_W = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start_i;
  logic [SET_W-1:0] settle_cycles_i;
  logic             ref_valid_i;
  logic [SMP_W-1:0] ref_sample_i;
  logic             sec_valid_i;
  logic [SMP_W-1:0] sec_sample_i;
  logic [TAP_W-1:0] dly_sel_o;
  logic             cal_done_o;
  logic [TAP_W-1:0] chosen_o;
  logic             cal_err_o;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dly_cal_sweep #(.TAP_W(TAP_W), .SMP_W(SMP_W), .WIN(8), .SET_W(SET_W)) u_dut (
    .clk (clk), .rst_n (rst_n), .start_i (start_i), .settle_cycles_i (settle_cycles_i),
    .ref_valid_i (ref_valid_i), .ref_sample_i (ref_sample_i),
    .sec_valid_i (sec_valid_i), .sec_sample_i (sec_sample_i),
    .dly_sel_o (dly_sel_o), .cal_done_o (cal_done_o),
    .chosen_o (chosen_o), .cal_err_o (cal_err_o)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  // stimulus model
  int lo1 = 16, hi1 = -1, lo2 = 16, hi2 = -1;
  int glitch_tap = -1;
  int settle_n = 0;
  bit noise_en = 1'b0;
  bit tie_en = 1'b0;
  bit arm = 1'b0;
  int last_sel = 0;
  int k = 0;
  int settle_left = 0;
  int incs = 0;
  bit phase = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int tap_delta(input int t);
    if ((t >= lo1 && t <= hi1) || (t >= lo2 && t <= hi2)) return 1;
    if (t < lo1) return tie_en ? 0 : -1;
    return tie_en ? 2 : 3;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      ref_valid_i  <= 1'b0;
      sec_valid_i  <= 1'b0;
      ref_sample_i <= '0;
      sec_sample_i <= '0;
      last_sel = 0;
      k = 0;
      phase = 1'b0;
    end else begin
      int d;
      if (start_i && arm) begin
        arm = 1'b0;
        k = 0;
        settle_left = settle_n + 1;
      end
      if (int'(dly_sel_o) != last_sel) begin
        if (int'(dly_sel_o) == last_sel + 1) incs++;
        last_sel = int'(dly_sel_o);
        k = 0;
        settle_left = settle_n;
      end
      d = tap_delta(int'(dly_sel_o));
      if (settle_left > 0) begin
        d = 3;
        settle_left--;
      end
      if (noise_en && phase) begin
        // R4: single-strobe junk
        phase = 1'b0;
        if (k % 2 == 0) begin
          ref_valid_i <= 1'b1; sec_valid_i <= 1'b0; ref_sample_i <= 8'd0; sec_sample_i <= 8'd255;
        end else begin
          ref_valid_i <= 1'b0; sec_valid_i <= 1'b1; ref_sample_i <= 8'd255; sec_sample_i <= 8'd255;
        end
      end else begin
        if (int'(dly_sel_o) == glitch_tap && k == 5) d = 3;
        ref_valid_i  <= 1'b1;
        sec_valid_i  <= 1'b1;
        ref_sample_i <= 8'(2 * k + 4);
        sec_sample_i <= 8'(2 * k + 4 + d);
        k++;
        phase = noise_en;
      end
    end
  end

  task automatic run_case(input int a_lo, input int a_hi, input int b_lo, input int b_hi,
                          input int g, input int stl, input bit nz, input bit tie,
                          input bit restart, input int exp_sel, input bit exp_err,
                          input int exp_chosen, input string tag);
    int cyc;
    @(negedge clk);
    #1;
    lo1 = a_lo; hi1 = a_hi; lo2 = b_lo; hi2 = b_hi;
    glitch_tap = g; settle_n = stl; noise_en = nz; tie_en = tie;
    settle_cycles_i = SET_W'(stl);
    incs = 0;
    arm = 1'b1;
    start_i = 1'b1;
    @(negedge clk);
    #1 start_i = 1'b0;
    cyc = 0;
    while (!cal_done_o && cyc < 4000) begin
      @(negedge clk);
      cyc++;
      #1 start_i = (restart && cyc == 60);
    end
    #1 start_i = 1'b0;
    chk(cal_done_o == 1'b1, {tag, " R2 done reached"}, int'(cal_done_o), 1);
    chk(int'(dly_sel_o) == exp_sel, {tag, exp_err ? " R9 sel restored" : " R8 sel centre"},
        int'(dly_sel_o), exp_sel);
    chk(int'(chosen_o) == exp_chosen, {tag, exp_err ? " R9 chosen kept" : " R8 chosen centre"},
        int'(chosen_o), exp_chosen);
    chk(cal_err_o == exp_err, {tag, " R8/R9 err flag"}, int'(cal_err_o), int'(exp_err));
    chk(incs == 15, {tag, " R2 ascending steps"}, incs, 15);
    repeat (10) @(negedge clk);
    chk(cal_done_o && cal_err_o == exp_err && int'(dly_sel_o) == exp_sel,
        {tag, " R10 outputs held"}, int'(dly_sel_o), exp_sel);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    start_i = 1'b0;
    settle_cycles_i = '0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(dly_sel_o == '0, "R1 reset sel", int'(dly_sel_o), 0);
    chk(chosen_o == '0, "R1 reset chosen", int'(chosen_o), 0);
    chk(cal_done_o == 1'b0, "R1 reset done", int'(cal_done_o), 0);
    chk(cal_err_o == 1'b0, "R1 reset err", int'(cal_err_o), 0);

    // R3 R4 R5 R6 R8: every single passing range
    for (int lo = 0; lo < 16; lo++) begin
      for (int hi = lo; hi < 16; hi++) begin
        run_case(lo, hi, 16, -1, -1, ((lo + hi) % 4) * 3, bit'((lo ^ hi) & 1),
                 bit'((lo + hi) & 1), 1'b0, (lo + hi) / 2, 1'b0, (lo + hi) / 2, "sweep");
      end
    end

    // R7: two disjoint runs, the first one wins
    run_case(2, 4, 9, 14, -1, 2, 1'b0, 1'b0, 1'b0, 3, 1'b0, 3, "R7 two ranges");
    // R6: one bad pair splits 3..12 at 7, first run 3..6
    run_case(3, 12, 16, -1, 7, 0, 1'b0, 1'b0, 1'b0, 4, 1'b0, 4, "R6 single bad pair");
    // R9: nothing passes, previous select 4 is restored
    run_case(16, -1, 16, -1, -1, 1, 1'b0, 1'b0, 1'b0, 4, 1'b1, 4, "R9 no range");
    // R2: start mid-sweep has no effect
    run_case(5, 10, 16, -1, -1, 3, 1'b0, 1'b0, 1'b1, 7, 1'b0, 7, "R2 restart ignored");

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule